// File: doc/BRIEF.md
# Dual-Compare Interval Timer

This block is an up-counting interval timer with two limit registers. A single-cycle `tick` input acts as its clock enable. While the timer is running, each tick advances the count. When the count would reach the active limit, it wraps to zero. That event is a terminal count. It sets a sticky flag and can raise a one-cycle interrupt pulse.

The timer has two limit modes. In single-limit mode, limit A sets the period and limit B is ignored. In dual-limit mode, phases timed by A and by B take turns. A status bit and the `wave_out` pin show which limit is active, so the pin carries a waveform whose high and low times are set separately. A limit value of zero gives a period of 2^WIDTH ticks. In one-shot mode, the timer clears its own run bit at the end of the period.

Software reaches four registers over a plain write/read bus with a combinational read port. The address map is 0 = control, 1 = count, 2 = limit A, 3 = limit B.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, the count, both limits and every control bit read as 0, `in_use_b` is 0, `wave_out` is 1 and `irq_pulse` is 0.
- R2: With the dual bit (control bit 3) clear, each tick of a running timer advances the count by one. On the tick where count+1 equals limit A, the count returns to 0 instead, so the period is A ticks. Limit B has no effect.
- R3: With the dual bit set, each terminal count toggles the active limit between A and B. `in_use_b`, also readable as control bit 6, is 1 while B is active. `wave_out` is 1 while A is active and 0 while B is active. Clearing the dual bit makes A active.
- R4: A limit value of 0 gives a period of 2^WIDTH ticks: the count reaches all ones and then wraps to 0 as a terminal count.
- R5: When the interrupt-enable bit (control bit 2) is set, `irq_pulse` is high for exactly the one cycle after a terminal-count tick. When it is clear, `irq_pulse` stays low.
- R6: With the continuous bit (control bit 4) clear, a terminal count clears the run bit (control bit 0). In single-limit mode this happens at the end of A. In dual-limit mode it happens only at the end of the B phase.
- R7: The reached flag (control bit 5) is set at every terminal count and stays set. A control write with bit 5 at 0 clears it, and a control write with bit 5 at 1 leaves it as it was.
- R8: A control write changes the run bit only if bit 1 of that same write is 1; otherwise the run bit keeps its value. Bit 1 always reads back as 0.
- R9: The count register can be written at any time, and the next tick counts on from the written value. A count write in the same cycle as a tick wins, and that tick is dropped.
- R10: The count does not change on cycles without a tick, or while the run bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one pulse per count step |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 control, 1 count, 2 limit A, 3 limit B) |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for `bus_addr`, combinational |
| wave_out | output | 1 | High while limit A is active, low while limit B is active |
| in_use_b | output | 1 | 1 while limit B is the active limit |
| irq_pulse | output | 1 | One-cycle terminal-count interrupt request |

## Verification
The single-limit runs use a limit A that is larger than limit B. A terminal count at A rather than at B shows that B is ignored, and a second run with the interrupt enable clear separates the flag from the pulse. Dual-limit runs with unequal A and B show whether the phase toggles at the right limit. The one-shot runs are done in both modes, which shows whether the stop waits for the end of the B phase. A full run with a zero limit tells the 2^WIDTH period apart from an immediate wrap. Control writes with and without the run-gate bit are checked against each other, and a count write that lands on a tick shows which of the two has priority.

// File: rtl/dct_pkg.sv
package dct_pkg;
    typedef enum logic [1:0] {
        REG_CTL  = 2'd0,
        REG_CNT  = 2'd1,
        REG_LIMA = 2'd2,
        REG_LIMB = 2'd3
    } dct_reg_e;

    localparam int unsigned CB_RUN  = 0;
    localparam int unsigned CB_WRUN = 1;
    localparam int unsigned CB_IRQ  = 2;
    localparam int unsigned CB_DUAL = 3;
    localparam int unsigned CB_CONT = 4;
    localparam int unsigned CB_HIT  = 5;
    localparam int unsigned CB_USEB = 6;
    localparam int unsigned CB_COUNT = 7;
endpackage

// File: rtl/dct_term.sv
module dct_term #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] count,
    input  logic [WIDTH-1:0] lim_a,
    input  logic [WIDTH-1:0] lim_b,
    input  logic             use_b,
    output logic             at_limit
);
    logic [WIDTH-1:0] nxt;
    logic [WIDTH-1:0] active;

    // A zero limit matches only when the incremented count wraps to zero,
    // which gives the full 2^WIDTH period.
    always_comb begin
        nxt      = count + WIDTH'(1);
        active   = use_b ? lim_b : lim_a;
        at_limit = (nxt == active);
    end
endmodule

// File: rtl/dct_rd_mux.sv
module dct_rd_mux #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [1:0]       addr,
    input  logic [WIDTH-1:0] ctl_word,
    input  logic [WIDTH-1:0] count,
    input  logic [WIDTH-1:0] lim_a,
    input  logic [WIDTH-1:0] lim_b,
    output logic [WIDTH-1:0] rdata
);
    import dct_pkg::*;

    always_comb begin
        unique case (dct_reg_e'(addr))
            REG_CTL:  rdata = ctl_word;
            REG_CNT:  rdata = count;
            REG_LIMA: rdata = lim_a;
            default:  rdata = lim_b;
        endcase
    end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    output logic             wave_out,
    output logic             in_use_b,
    output logic             irq_pulse
);
    import dct_pkg::*;

    localparam int unsigned CTL_PAD = WIDTH - CB_COUNT;

    typedef struct packed {
        logic [WIDTH-1:0] count;
        logic [WIDTH-1:0] lim_a;
        logic [WIDTH-1:0] lim_b;
        logic             run;
        logic             irq_en;
        logic             dual;
        logic             cont;
        logic             reached;
        logic             use_b;
        logic             irq;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    logic             at_limit;
    logic             wr_ctl, wr_cnt, wr_lima, wr_limb;
    logic             step;
    logic             hit;
    logic [WIDTH-1:0] ctl_word;
    logic [WIDTH-1:0] cnt_w;
    logic             run_w;
    logic             reached_w;

    dct_term #(.WIDTH(WIDTH)) u_term (
        .count    (st_q.count),
        .lim_a    (st_q.lim_a),
        .lim_b    (st_q.lim_b),
        .use_b    (st_q.use_b),
        .at_limit (at_limit)
    );

    always_comb begin
        ctl_word          = '0;
        ctl_word[CB_RUN]  = st_q.run;
        ctl_word[CB_IRQ]  = st_q.irq_en;
        ctl_word[CB_DUAL] = st_q.dual;
        ctl_word[CB_CONT] = st_q.cont;
        ctl_word[CB_HIT]  = st_q.reached;
        ctl_word[CB_USEB] = st_q.use_b;
    end

    dct_rd_mux #(.WIDTH(WIDTH)) u_rd (
        .addr     (bus_addr),
        .ctl_word (ctl_word),
        .count    (st_q.count),
        .lim_a    (st_q.lim_a),
        .lim_b    (st_q.lim_b),
        .rdata    (bus_rdata)
    );

    always_comb begin
        wr_ctl  = bus_wr && (bus_addr == REG_CTL);
        wr_cnt  = bus_wr && (bus_addr == REG_CNT);
        wr_lima = bus_wr && (bus_addr == REG_LIMA);
        wr_limb = bus_wr && (bus_addr == REG_LIMB);
        // A count write takes the whole cycle; the tick it meets is dropped.
        step    = tick && st_q.run && !wr_cnt;
        hit     = step && at_limit;

        st_d     = st_q;
        st_d.irq = 1'b0;
        if (!st_q.dual) begin
            st_d.use_b = 1'b0;
        end

        if (step) begin
            st_d.count = at_limit ? '0 : st_q.count + WIDTH'(1);
        end

        if (hit) begin
            st_d.reached = 1'b1;
            st_d.irq     = st_q.irq_en;
            if (st_q.dual) begin
                st_d.use_b = !st_q.use_b;
            end
            // One-shot: dual mode stops only after the B phase ends.
            if (!st_q.cont && (!st_q.dual || st_q.use_b)) begin
                st_d.run = 1'b0;
            end
        end

        if (wr_cnt) begin
            st_d.count = bus_wdata;
        end
        if (wr_lima) begin
            st_d.lim_a = bus_wdata;
        end
        if (wr_limb) begin
            st_d.lim_b = bus_wdata;
        end
        if (wr_ctl) begin
            st_d.irq_en = bus_wdata[CB_IRQ];
            st_d.dual   = bus_wdata[CB_DUAL];
            st_d.cont   = bus_wdata[CB_CONT];
            if (bus_wdata[CB_WRUN]) begin
                st_d.run = bus_wdata[CB_RUN];
            end
            if (!bus_wdata[CB_HIT]) begin
                st_d.reached = hit;
            end
            if (!bus_wdata[CB_DUAL]) begin
                st_d.use_b = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wave_out  = !st_q.use_b;
    assign in_use_b  = st_q.use_b;
    assign irq_pulse = st_q.irq;
    assign cnt_w     = st_q.count;
    assign run_w     = st_q.run;
    assign reached_w = st_q.reached;

    if (CTL_PAD == 0) begin : g_chk_width
        initial $display("dual_cmp_timer: WIDTH leaves no spare control bits");
    end
endmodule

// File: rtl/dct_chk.sv
module dct_chk #(
    parameter int unsigned WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic             irq_pulse,
    input logic             in_use_b,
    input logic             wave_out,
    input logic [WIDTH-1:0] cnt_w,
    input logic             run_w,
    input logic             reached_w
);
    logic wr_ctl, wr_cnt;
    assign wr_ctl = bus_wr && (bus_addr == 2'd0);
    assign wr_cnt = bus_wr && (bus_addr == 2'd1);

    // R5: a pulse follows a tick and lasts one cycle
    assert_irq_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(tick));
    assert_irq_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);
    // R2: terminal count leaves the count at zero
    assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (cnt_w == '0));
    // R7: terminal count leaves the flag set
    assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> reached_w);
    // R10: stopped timer makes no terminal count
    assert_stopped_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_w |=> !irq_pulse);
    // R10: no tick and no count write, count holds
    assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_cnt) |=> $stable(cnt_w));
    // R3: active limit changes only on a tick or a control write
    assert_sel_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(in_use_b) |-> ($past(tick) || $past(wr_ctl)));
    // R3: pin level opposite to the B-active status
    always @(negedge clk) begin
        if (rst_n) begin
            assert_wave_level_R3: assert (wave_out == !in_use_b);
        end
    end
endmodule

bind dual_cmp_timer dct_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .irq_pulse (irq_pulse),
    .in_use_b  (in_use_b),
    .wave_out  (wave_out),
    .cnt_w     (cnt_w),
    .run_w     (run_w),
    .reached_w (reached_w)
);

// File: tb/tb_dual_cmp_timer.sv
`timescale 1ns/1ps
module tb_dual_cmp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        wave_out, in_use_b, irq_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dual_cmp_timer #(.WIDTH(16)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wave_out(wave_out), .in_use_b(in_use_b), .irq_pulse(irq_pulse)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(2'd0, v); check("R1 ctl", v, 16'h0);
        rd(2'd1, v); check("R1 count", v, 16'h0);
        rd(2'd2, v); check("R1 limA", v, 16'h0);
        rd(2'd3, v); check("R1 limB", v, 16'h0);
        check("R1 wave", 16'(wave_out), 16'h1);
        check("R1 in_use_b", 16'(in_use_b), 16'h0);
        check("R1 irq", 16'(irq_pulse), 16'h0);
    endtask

    task automatic t_single;
        logic [15:0] v;
        wr(2'd2, 16'd5);
        wr(2'd3, 16'd2);
        wr(2'd0, 16'h17);
        ticks(4);
        rd(2'd1, v); check("R2 count past B", v, 16'd4);
        check("R5 no early irq", 16'(irq_pulse), 16'h0);
        ticks(1);
        rd(2'd1, v); check("R2 wrap at A", v, 16'd0);
        check("R5 irq pulse", 16'(irq_pulse), 16'h1);
        rd(2'd0, v); check("R7 flag set, r8_ bit1 reads 0", v, 16'h35);
        ticks(1);
        check("R5 pulse ends", 16'(irq_pulse), 16'h0);
        rd(2'd1, v); check("R2 count resumes", v, 16'd1);
        wr(2'd0, 16'h37);
        rd(2'd0, v); check("R7 write 1 keeps flag", v, 16'h35);
        wr(2'd0, 16'h17);
        rd(2'd0, v); check("R7 write 0 clears flag", v, 16'h15);
    endtask

    task automatic t_irq_off;
        logic [15:0] v;
        wr(2'd0, 16'h13);
        ticks(4);
        check("R5 no irq when disabled", 16'(irq_pulse), 16'h0);
        rd(2'd0, v); check("R7 flag without irq", v, 16'h31);
        rd(2'd1, v); check("R2 wrapped", v, 16'd0);
    endtask

    task automatic t_stopped;
        logic [15:0] v;
        wr(2'd0, 16'h12);
        rd(2'd0, v); check("R8 run cleared with gate", v, 16'h10);
        ticks(5);
        rd(2'd1, v); check("R10 no count while stopped", v, 16'd0);
        wr(2'd0, 16'h11);
        rd(2'd0, v); check("R8 run kept without gate", v, 16'h10);
        ticks(3);
        rd(2'd1, v); check("R8 still stopped", v, 16'd0);
        wr(2'd2, 16'd100);
        wr(2'd0, 16'h13);
        repeat (5) @(negedge clk);
        rd(2'd1, v); check("R10 no count without tick", v, 16'd0);
    endtask

    task automatic t_count_write;
        logic [15:0] v;
        wr(2'd1, 16'd3);
        ticks(1);
        rd(2'd1, v); check("R9 counts from written", v, 16'd4);
        @(negedge clk);
        tick = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 16'd10;
        @(negedge clk);
        tick = 1'b0; bus_wr = 1'b0;
        rd(2'd1, v); check("R9 write beats tick", v, 16'd10);
        ticks(1);
        rd(2'd1, v); check("R9 next tick", v, 16'd11);
    endtask

    task automatic t_dual;
        logic [15:0] v;
        wr(2'd0, 16'h12);
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd3);
        wr(2'd3, 16'd2);
        wr(2'd0, 16'h1F);
        check("R3 A phase wave", 16'(wave_out), 16'h1);
        ticks(3);
        check("R3 B active", 16'(in_use_b), 16'h1);
        check("R3 B phase wave", 16'(wave_out), 16'h0);
        check("R5 irq at A end", 16'(irq_pulse), 16'h1);
        rd(2'd0, v); check("R3 status bit6", v, 16'h7D);
        ticks(2);
        check("R3 back to A", 16'(in_use_b), 16'h0);
        check("R3 wave high again", 16'(wave_out), 16'h1);
        check("R5 irq at B end", 16'(irq_pulse), 16'h1);
    endtask

    task automatic t_oneshot;
        logic [15:0] v;
        wr(2'd0, 16'h12);
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd4);
        wr(2'd0, 16'h07);
        ticks(4);
        rd(2'd0, v); check("R6 single stops", v, 16'h24);
        ticks(3);
        rd(2'd1, v); check("R6 stays stopped", v, 16'd0);
        wr(2'd2, 16'd2);
        wr(2'd3, 16'd3);
        wr(2'd0, 16'h0F);
        ticks(2);
        rd(2'd0, v); check("R6 dual runs after A", v, 16'h6D);
        ticks(3);
        rd(2'd0, v); check("R6 dual stops after B", v, 16'h2C);
        ticks(2);
        rd(2'd1, v); check("R6 dual stays stopped", v, 16'd0);
    endtask

    task automatic t_zero_limit;
        logic [15:0] v;
        wr(2'd0, 16'h12);
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd0);
        wr(2'd0, 16'h13);
        ticks(65535);
        rd(2'd1, v); check("R4 reaches all ones", v, 16'hFFFF);
        rd(2'd0, v); check("R4 no early terminal", v, 16'h11);
        ticks(1);
        rd(2'd1, v); check("R4 wraps", v, 16'd0);
        rd(2'd0, v); check("R4 terminal flag", v, 16'h31);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_irq_off();
        t_stopped();
        t_count_write();
        t_dual();
        t_oneshot();
        t_zero_limit();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule